// File: doc/BRIEF.md
# Adaptive Synchronization Time Controller

This block passes an asynchronous input into the destination clock domain through a chain of flip-flops whose depth is chosen at run time, rather than fixed at a worst-case figure. Next to the chain, a metastability detector supplies two per-cycle failure flags. One flag is taken at an early sample point and one at a later sample point of the first stage, half a clock cycle apart. On a trigger, the controller counts both flags over a window of fixed length. From the two counts it works out how fast metastable events resolve, and so predicts the mean time between failures for each candidate depth.

All arithmetic is done as base-2 logarithms in fixed point with 8 fractional bits. A leading-one detector and a 16-entry mantissa table produce the logarithm, so no exponential or division is needed. The controller picks the shallowest depth whose predicted log2 MTBF (in destination clock cycles) reaches the programmed target. It holds that choice until the next window closes. The trigger can be repeated at any rate, so the setting can follow supply or data-rate drift.

Top module: `adapt_sync_ctrl`

## Requirements
- R1: While reset is high, `delay_code` is MAX_EXTRA-1 (the deepest path) and `path_valid` is 0. On the first clock edge after reset, `path_valid` rises to 1.
- R2: A `delay_code` of k selects k+1 extra stages behind the first stage. A change on `async_in` reaches `sync_out` on the (k+2)-th rising edge after it is set up.
- R3: A window starts on an edge where `meas_go` is high and no window is running. It counts `det_early` and `det_late` on exactly 2^WIN_LOG2 following edges. Flags outside a window are not counted, and `meas_go` has no effect while a window runs.
- R4: A count v is mapped to L(v) = 256*p + F(m). Here p is the bit position of v's leading one, m is the 4 bits just below it (zero-padded), and F(m) = round(256*log2(1+m/16)). Example: L(48) = 1430 and L(64) = 1536.
- R5: With E = L(early count) and D = L(late count), the score for d extra stages is 256*WIN_LOG2 - E + (2d+1)*(E - D). The controller picks the smallest d from 1 to MAX_EXTRA whose score is greater than or equal to `mtbf_target`, and reports it as `delay_code` = d-1.
- R6: When no depth reaches the target, `delay_code` becomes MAX_EXTRA-1.
- R7: When the late count is zero, or is not below the early count, `delay_code` becomes MAX_EXTRA-1 whatever the target.
- R8: `delay_code` changes only on the edge right after a window's last counting edge. Changes to `mtbf_target` or the flags between windows leave it unchanged.
- R9: On that update edge, `path_valid` goes to 0 for exactly one cycle if the new code differs from the old one. It stays 1 if the code is the same.
- R10: Every window starts from zero counts, and its decision replaces the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination clock |
| rst | input | 1 | Synchronous active-high reset |
| async_in | input | 1 | Asynchronous data to be synchronized |
| det_early | input | 1 | Failure flag from the early detector sample point |
| det_late | input | 1 | Failure flag from the late detector sample point |
| meas_go | input | 1 | Starts a measurement window |
| mtbf_target | input | TGT_W | Required log2 MTBF in cycles, 8 fractional bits |
| sync_out | output | 1 | Synchronized data |
| delay_code | output | DW | Selected depth, extra stages minus one |
| path_valid | output | 1 | Low for one cycle while the output path switches |

## Verification
The start edge opens a window. After 2^WIN_LOG2 counting edges, one more edge (the update edge) produces the decision and any drop in `path_valid`. `path_valid` returns high one edge later. The bench counts these edges explicitly and samples `delay_code` and `path_valid` at the falling edge after the update edge, then again one cycle later. For the data path, the bench counts k+2 rising edges from the input change, and checks both the edge just before arrival and the arrival edge.

// File: rtl/adsync_pkg.sv
package adsync_pkg;

    localparam int CNT_W  = 16;
    localparam int FRAC_W = 8;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_COUNT,
        WS_DECIDE
    } win_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] early_cnt;
        logic [CNT_W-1:0] late_cnt;
    } fail_counts_t;

    // round(256 * log2(1 + idx/16))
    function automatic logic [FRAC_W-1:0] mant_frac(input logic [3:0] idx);
        logic [FRAC_W-1:0] r;
        case (idx)
            4'd0:  r = 8'd0;
            4'd1:  r = 8'd22;
            4'd2:  r = 8'd44;
            4'd3:  r = 8'd63;
            4'd4:  r = 8'd82;
            4'd5:  r = 8'd100;
            4'd6:  r = 8'd118;
            4'd7:  r = 8'd134;
            4'd8:  r = 8'd150;
            4'd9:  r = 8'd165;
            4'd10: r = 8'd179;
            4'd11: r = 8'd193;
            4'd12: r = 8'd207;
            4'd13: r = 8'd220;
            4'd14: r = 8'd232;
            default: r = 8'd244;
        endcase
        return r;
    endfunction

    // Fixed-point log2 (8 fractional bits) via leading-one position and table
    function automatic logic [15:0] log2_q8(input logic [CNT_W-1:0] v);
        int               lead;
        logic [CNT_W-1:0] norm;
        lead = 0;
        for (int i = 0; i < CNT_W; i++) begin
            if (v[i]) lead = i;
        end
        norm = v << (CNT_W - 1 - lead);
        return 16'(lead * 256) + 16'(mant_frac(norm[CNT_W-2 -: 4]));
    endfunction

endpackage

// File: rtl/adsync_chain.sv
module adsync_chain #(
    parameter int MAX_EXTRA = 4,
    localparam int DW = $clog2(MAX_EXTRA)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d_in,
    input  logic [DW-1:0] sel,
    output logic          q_out
);
    logic [MAX_EXTRA:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= d_in;
    end

    for (genvar k = 1; k <= MAX_EXTRA; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= 1'b0;
            else     stg[k] <= stg[k-1];
        end
    end

    always_comb begin
        q_out = stg[1];
        for (int k = 0; k < MAX_EXTRA; k++) begin
            if (sel == DW'(k)) q_out = stg[k+1];
        end
    end

    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        stg[0] |=> stg[1]); // R2
endmodule

// File: rtl/adsync_window.sv
module adsync_window
    import adsync_pkg::*;
#(
    parameter int WIN_LOG2 = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         flag_early,
    input  logic         flag_late,
    output fail_counts_t counts,
    output logic         done
);
    localparam logic [WIN_LOG2-1:0] LAST = '1;
    localparam logic [CNT_W-1:0]    WIN_LEN = CNT_W'(1) << WIN_LOG2;

    win_state_e          state;
    logic [WIN_LOG2-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WS_IDLE;
            tick   <= '0;
            counts <= '0;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    state  <= WS_COUNT;
                    tick   <= '0;
                    counts <= '0;
                end
                WS_COUNT: begin
                    counts.early_cnt <= counts.early_cnt + CNT_W'(flag_early);
                    counts.late_cnt  <= counts.late_cnt  + CNT_W'(flag_late);
                    tick             <= tick + 1'b1;
                    if (tick == LAST) state <= WS_DECIDE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign done = (state == WS_DECIDE);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        counts.early_cnt <= WIN_LEN && counts.late_cnt <= WIN_LEN); // R3
    AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (state == WS_COUNT && tick == LAST) |=> done); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state == WS_COUNT && tick != LAST) |=> state == WS_COUNT); // R3
endmodule

// File: rtl/adsync_picker.sv
module adsync_picker
    import adsync_pkg::*;
#(
    parameter int MAX_EXTRA = 4,
    parameter int WIN_LOG2  = 8,
    parameter int TGT_W     = 16,
    localparam int DW = $clog2(MAX_EXTRA),
    localparam int SW = 24
) (
    input  fail_counts_t     counts,
    input  logic [TGT_W-1:0] target,
    output logic [DW-1:0]    pick,
    output logic             fallback
);
    localparam int BASE = WIN_LOG2 * 256;

    logic signed [SW-1:0] l_early, l_late, tgt_s;
    logic [MAX_EXTRA-1:0] meets;

    assign l_early  = SW'(log2_q8(counts.early_cnt));
    assign l_late   = SW'(log2_q8(counts.late_cnt));
    assign tgt_s    = SW'(target);
    assign fallback = (counts.late_cnt == '0) || (counts.late_cnt >= counts.early_cnt);

    for (genvar d = 0; d < MAX_EXTRA; d++) begin : g_cand
        logic signed [SW-1:0] score;
        assign score    = SW'(BASE) - l_early + SW'(2*d + 3) * (l_early - l_late);
        assign meets[d] = (score >= tgt_s);
    end

    always_comb begin
        pick = DW'(MAX_EXTRA - 1);
        for (int d = MAX_EXTRA - 1; d >= 0; d--) begin
            if (meets[d]) pick = DW'(d);
        end
        if (fallback) pick = DW'(MAX_EXTRA - 1);
    end
endmodule

// File: rtl/adapt_sync_ctrl.sv
module adapt_sync_ctrl
    import adsync_pkg::*;
#(
    parameter int MAX_EXTRA = 4,
    parameter int WIN_LOG2  = 8,
    parameter int TGT_W     = 16,
    localparam int DW = $clog2(MAX_EXTRA)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             async_in,
    input  logic             det_early,
    input  logic             det_late,
    input  logic             meas_go,
    input  logic [TGT_W-1:0] mtbf_target,
    output logic             sync_out,
    output logic [DW-1:0]    delay_code,
    output logic             path_valid
);
    fail_counts_t  counts;
    logic          win_done;
    logic [DW-1:0] pick;
    logic          fallback;

    adsync_chain #(.MAX_EXTRA(MAX_EXTRA)) u_chain (
        .clk(clk), .rst(rst), .d_in(async_in), .sel(delay_code), .q_out(sync_out)
    );

    adsync_window #(.WIN_LOG2(WIN_LOG2)) u_window (
        .clk(clk), .rst(rst), .start(meas_go), .flag_early(det_early),
        .flag_late(det_late), .counts(counts), .done(win_done)
    );

    adsync_picker #(.MAX_EXTRA(MAX_EXTRA), .WIN_LOG2(WIN_LOG2), .TGT_W(TGT_W)) u_picker (
        .counts(counts), .target(mtbf_target), .pick(pick), .fallback(fallback)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            delay_code <= DW'(MAX_EXTRA - 1);
            path_valid <= 1'b0;
        end else if (win_done) begin
            delay_code <= pick;
            path_valid <= (pick == delay_code);
        end else begin
            path_valid <= 1'b1;
        end
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !win_done |=> $stable(delay_code)); // R8
    AST_FALLBACK_MAX: assert property (@(posedge clk) disable iff (rst)
        (win_done && fallback) |=> delay_code == DW'(MAX_EXTRA - 1)); // R7
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        (win_done && pick != delay_code) |=> !path_valid); // R9
    AST_VALID_KEEP: assert property (@(posedge clk) disable iff (rst)
        (win_done && pick == delay_code) |=> path_valid); // R9
    AST_VALID_RESTORE: assert property (@(posedge clk) disable iff (rst)
        !path_valid |=> path_valid); // R9
endmodule

// File: tb/sim_adapt_sync_ctrl.sv
module sim_adapt_sync_ctrl;
    localparam int MAX_EXTRA = 4;
    localparam int WIN_LOG2  = 8;
    localparam int TGT_W     = 16;
    localparam int WLEN      = 1 << WIN_LOG2;
    localparam int NV        = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              async_in = 1'b0;
    logic              det_early = 1'b0;
    logic              det_late = 1'b0;
    logic              meas_go = 1'b0;
    logic [TGT_W-1:0]  mtbf_target = '0;
    logic              sync_out;
    logic [1:0]        delay_code;
    logic              path_valid;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    adapt_sync_ctrl #(.MAX_EXTRA(MAX_EXTRA), .WIN_LOG2(WIN_LOG2), .TGT_W(TGT_W)) u0 (
        .clk(clk), .rst(rst), .async_in(async_in), .det_early(det_early),
        .det_late(det_late), .meas_go(meas_go), .mtbf_target(mtbf_target),
        .sync_out(sync_out), .delay_code(delay_code), .path_valid(path_valid)
    );

    // {early count, late count, target, expected code}; scores per R4/R5
    typedef struct packed {
        logic [15:0] c_early;
        logic [15:0] c_late;
        logic [15:0] tgt;
        logic [1:0]  code;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'd64,  16'd16, 16'd3000, 2'd1},  // scores 2048/3072/4096/5120
        '{16'd64,  16'd16, 16'd2048, 2'd0},  // equality meets
        '{16'd64,  16'd16, 16'd2047, 2'd0},
        '{16'd64,  16'd16, 16'd3072, 2'd1},
        '{16'd64,  16'd16, 16'd5000, 2'd3},
        '{16'd64,  16'd16, 16'd6000, 2'd3},  // none meets (R6)
        '{16'd128, 16'd64, 16'd2000, 2'd2},  // scores 1024/1536/2048/2560
        '{16'd128, 16'd64, 16'd1024, 2'd0},
        '{16'd128, 16'd64, 16'd1025, 2'd1},
        '{16'd48,  16'd3,  16'd4000, 2'd1},  // L(48)=1430, L(3)=406
        '{16'd50,  16'd0,  16'd0,    2'd3},  // late zero (R7)
        '{16'd20,  16'd20, 16'd0,    2'd3},  // equal counts (R7)
        '{16'd10,  16'd30, 16'd0,    2'd3}   // late above early (R7)
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Opens a window and feeds c_e/c_l flags on its first counting edges.
    // poke re-asserts meas_go mid-window, which must have no effect (R3).
    task automatic run_window(input int c_e, input int c_l, input bit poke);
        @(negedge clk);
        meas_go = 1'b1;
        @(posedge clk);                       // start edge
        for (int i = 0; i < WLEN; i++) begin
            @(negedge clk);
            meas_go   = poke && (i == 100);
            det_early = (i < c_e);
            det_late  = (i < c_l);
            @(posedge clk);                   // counting edge
        end
        @(negedge clk);
        meas_go   = 1'b0;
        det_early = 1'b0;
        det_late  = 1'b0;
        @(posedge clk);                       // update edge
    endtask

    initial begin
        int prev_code;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(delay_code == 2'd3, "R1 reset code", delay_code, 3);
        check(path_valid == 1'b0, "R1 reset valid", path_valid, 0);
        rst = 1'b0;
        async_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(path_valid == 1'b1, "R1 valid after reset", path_valid, 1);
        // R2 latency with code 3: arrival on the fifth edge
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sync_out == 1'b0, "R2 before arrival k=3", sync_out, 0);
        @(posedge clk);
        @(negedge clk);
        check(sync_out == 1'b1, "R2 arrival k=3", sync_out, 1);

        // Flags between windows are ignored (R3)
        det_early = 1'b1;
        det_late  = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        det_early = 1'b0;
        det_late  = 1'b0;

        prev_code = 3;
        // Vector walk: R4 R5 R6 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            mtbf_target = VECS[v].tgt;
            run_window(int'(VECS[v].c_early), int'(VECS[v].c_late), v == 0);
            @(negedge clk);
            check(delay_code == VECS[v].code, "R5/R6/R7 pick", delay_code, VECS[v].code);
            check(path_valid == (int'(VECS[v].code) == prev_code), "R9 valid on update",
                  path_valid, int'(VECS[v].code) == prev_code);
            @(posedge clk);
            @(negedge clk);
            check(path_valid == 1'b1, "R9 valid restored", path_valid, 1);
            prev_code = int'(VECS[v].code);
        end

        // R8: target and flag changes between windows leave the code alone
        mtbf_target = 16'd0;
        det_early = 1'b1;
        repeat (15) @(posedge clk);
        @(negedge clk);
        det_early = 1'b0;
        check(delay_code == 2'd3, "R8 hold between windows", delay_code, 3);

        // R10 + R2: fresh window gives code 0, then latency of two edges
        mtbf_target = 16'd2048;
        run_window(64, 16, 1'b0);
        @(negedge clk);
        check(delay_code == 2'd0, "R10 new decision", delay_code, 0);
        async_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(sync_out == 1'b1, "R2 before arrival k=0", sync_out, 1);
        @(posedge clk);
        @(negedge clk);
        check(sync_out == 1'b0, "R2 arrival k=0", sync_out, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule